// File: doc/BRIEF.md
# Half-Bridge Gate-Drive Interlock Controller

This block controls one phase leg of an inverter. It turns a high-side and a low-side PWM command into two gate-enable outputs. It never lets the two switches conduct together. When both commands are asserted it turns both switches off. Each hand-over between the sides waits for a parameterised dead time, counted in clock cycles, before the incoming side is enabled.

The block has three ways to force both gates off. The first is an active-low shutdown line, sampled as a digital level. The second is an undervoltage flag, which arrives already debounced. The third is an overcurrent comparator flag. The overcurrent path works in two ways at once:

- It clears both gates on the next clock edge, without waiting for the shutdown line to fall.
- It latches a pull-down request for the shared open-drain shutdown line. The request stays set until the line has actually been read low.

The command, shutdown and overcurrent inputs pass through a synchroniser before the main logic uses them. After any forced-off condition, the outputs stay off until both commands have been seen low together. Only then do they return, and they return through the normal dead-time path.

Top module: `hb_gate_interlock`

## Requirements
- R1: While reset is asserted, and on the first cycle after its release, `gate_hi`, `gate_lo` and `sd_pull` are all 0.
- R2: A low level on `sd_line_n` forces both gate outputs to 0 no later than 3 clock edges after the low level is first sampled, whatever the commands are.
- R3: When `cmd_hi` and `cmd_lo` are both 1, both gate outputs are 0, 3 edges after that input pair is sampled.
- R4: With no forced-off condition and the leg armed, the outputs decode the commands as follows. `cmd_hi`=1 with `cmd_lo`=0 enables only `gate_hi`. `cmd_lo`=1 with `cmd_hi`=0 enables only `gate_lo`. Both commands at 0 disables both outputs.
- R5: `gate_hi` and `gate_lo` are never 1 in the same cycle.
- R6: An output is enabled only after both outputs have been 0 for at least `DEAD_CYC` consecutive cycles. On a direct hand-over from one side to the other, the both-off gap is exactly `DEAD_CYC` cycles.
- R7: An `oc_flag` of 1 sampled at a clock edge makes both gate outputs 0 from that edge on.
- R8: `sd_pull` rises 3 edges after `oc_flag` is first sampled high. It then stays at 1, even after `oc_flag` has dropped, until `sd_line_n` is sampled 0 while `oc_flag` is 0. It falls 3 edges after that sample.
- R9: A `uv_flag` of 1 sampled at a clock edge makes both gate outputs 0 from that edge on.
- R10: After reset, shutdown, overcurrent or undervoltage, the outputs stay 0 until both commands have been sampled 0 in the same cycle with no forced-off condition present.
- R11: Once armed and with the dead time already satisfied, a new command appears on its gate output 3 clock edges after it is first sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_hi | input | 1 | High-side PWM command, active high |
| cmd_lo | input | 1 | Low-side PWM command, active high |
| sd_line_n | input | 1 | Sampled level of the shared shutdown line, active low |
| oc_flag | input | 1 | Overcurrent comparator output, 1 = tripped |
| uv_flag | input | 1 | Debounced supply undervoltage flag, 1 = undervoltage |
| gate_hi | output | 1 | High-side gate enable |
| gate_lo | output | 1 | Low-side gate enable |
| sd_pull | output | 1 | Request to pull the shutdown line low (open-drain drive) |

## Verification
Each result has its own latency, counted from the clock edge at which a stimulus is first sampled:

| Stimulus | Result | Due after |
|----------|--------|-----------|
| Overcurrent or undervoltage | Gates off | 1 edge |
| New command | Gate change | 3 edges (2 synchroniser stages plus the output register) |
| Shutdown level | Gates off | 3 edges |
| Overcurrent | Pull-down request set | 3 edges |
| Shutdown line read low | Pull-down request cleared | 3 edges |
| Hand-over between sides | Opposite gate enabled | `DEAD_CYC` both-off cycles |

The bench changes inputs on falling edges and reads outputs on the next falling edge, so every edge count above is exact. A behavioural model advances on each rising edge and is compared on every falling edge. Directed checks count falling edges to confirm each latency, including the cycle just before a result is due.

// File: rtl/hbgi_pkg.sv
package hbgi_pkg;

   typedef enum logic [1:0] {
      DRV_OFF  = 2'd0,
      DRV_HIGH = 2'd1,
      DRV_LOW  = 2'd2
   } drv_e;

   // Map a command pair onto the side to be driven; a clash turns the leg off.
   function automatic drv_e decode_cmd(input logic hi, input logic lo);
      drv_e r;
      unique case ({hi, lo})
         2'b10:   r = DRV_HIGH;
         2'b01:   r = DRV_LOW;
         default: r = DRV_OFF;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/hbgi_sync.sv
module hbgi_sync #(
   parameter int           W       = 1,
   parameter int           STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= RST_VAL;
            else        stg[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= RST_VAL;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/hbgi_fault.sv
module hbgi_fault (
   input  logic clk,
   input  logic rst_n,
   input  logic oc_raw,
   input  logic oc_s,
   input  logic sd_n_s,
   input  logic uv,
   input  logic hi_s,
   input  logic lo_s,
   output logic kill,
   output logic armed,
   output logic pull
);

   logic pull_q;
   logic arm_q;

   // The raw comparator flag only clears the gates, which is the safe direction.
   assign kill = !sd_n_s | uv | oc_raw | oc_s | pull_q;

   // Latched pull-down request; a new trip wins over the release.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pull_q <= 1'b0;
      else if (oc_s)    pull_q <= 1'b1;
      else if (!sd_n_s) pull_q <= 1'b0;
   end

   // Re-arm needs a quiet command pair after every forced-off period.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              arm_q <= 1'b0;
      else if (kill)           arm_q <= 1'b0;
      else if (!hi_s && !lo_s) arm_q <= 1'b1;
   end

   assign armed = arm_q;
   assign pull  = pull_q;

endmodule

// File: rtl/hbgi_dead_time.sv
module hbgi_dead_time
   import hbgi_pkg::*;
#(
   parameter int DEAD_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  drv_e want,
   output logic gate_hi,
   output logic gate_lo
);

   logic gh_q, gl_q;
   logic both_low;
   logic gap_ok;

   assign both_low = !gh_q && !gl_q;

   if (DEAD_CYC == 1) begin : g_single
      // One off cycle is already guaranteed by the output register.
      assign gap_ok = both_low;
   end else begin : g_count
      localparam int          CW       = $clog2(DEAD_CYC);
      localparam logic [CW-1:0] IDLE_MAX = CW'(DEAD_CYC - 1);
      logic [CW-1:0] idle_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)               idle_q <= '0;
         else if (!both_low)       idle_q <= '0;
         else if (idle_q != IDLE_MAX) idle_q <= idle_q + 1'b1;
      end

      assign gap_ok = both_low && (idle_q == IDLE_MAX);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gh_q <= 1'b0;
         gl_q <= 1'b0;
      end else begin
         gh_q <= (want == DRV_HIGH) && (gh_q || gap_ok);
         gl_q <= (want == DRV_LOW)  && (gl_q || gap_ok);
      end
   end

   assign gate_hi = gh_q;
   assign gate_lo = gl_q;

endmodule

// File: rtl/hb_gate_interlock.sv
module hb_gate_interlock
   import hbgi_pkg::*;
#(
   parameter int DEAD_CYC    = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_hi,
   input  logic cmd_lo,
   input  logic sd_line_n,
   input  logic oc_flag,
   input  logic uv_flag,
   output logic gate_hi,
   output logic gate_lo,
   output logic sd_pull
);

   localparam int NSYNC = 4;

   if (DEAD_CYC < 1) begin : g_bad_dead
      $error("DEAD_CYC must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [NSYNC-1:0] raw_v, syn_v;
   logic hi_s, lo_s, sd_n_s, oc_s;
   logic kill, armed;
   drv_e want;

   assign raw_v = {sd_line_n, oc_flag, cmd_lo, cmd_hi};

   // Shutdown line resets to its active (low) state so the leg starts off.
   hbgi_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(4'b0000)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_v),
      .q     (syn_v)
   );

   assign hi_s   = syn_v[0];
   assign lo_s   = syn_v[1];
   assign oc_s   = syn_v[2];
   assign sd_n_s = syn_v[3];

   hbgi_fault u_fault (
      .clk    (clk),
      .rst_n  (rst_n),
      .oc_raw (oc_flag),
      .oc_s   (oc_s),
      .sd_n_s (sd_n_s),
      .uv     (uv_flag),
      .hi_s   (hi_s),
      .lo_s   (lo_s),
      .kill   (kill),
      .armed  (armed),
      .pull   (sd_pull)
   );

   assign want = (kill || !armed) ? DRV_OFF : decode_cmd(hi_s, lo_s);

   hbgi_dead_time #(.DEAD_CYC(DEAD_CYC)) u_dead (
      .clk     (clk),
      .rst_n   (rst_n),
      .want    (want),
      .gate_hi (gate_hi),
      .gate_lo (gate_lo)
   );

endmodule

// File: rtl/hbgi_chk.sv
module hbgi_chk #(
   parameter int DEAD_CYC    = 8,
   parameter int SYNC_STAGES = 2
) (
   input logic clk,
   input logic rst_n,
   input logic cmd_hi,
   input logic cmd_lo,
   input logic sd_line_n,
   input logic oc_flag,
   input logic uv_flag,
   input logic gate_hi,
   input logic gate_lo,
   input logic sd_pull
);

   localparam int RW = $clog2(DEAD_CYC + 1) + 1;
   logic [RW-1:0] off_run;

   // Cycles both gates have been off, saturating at DEAD_CYC.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   off_run <= '0;
      else if (gate_hi || gate_lo)  off_run <= '0;
      else if (off_run < RW'(DEAD_CYC)) off_run <= off_run + 1'b1;
   end

   a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hi && gate_lo));

   a_r6_gap_hi: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_hi) |-> off_run >= RW'(DEAD_CYC));

   a_r6_gap_lo: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_lo) |-> off_run >= RW'(DEAD_CYC));

   a_r7_oc_kill: assert property (@(posedge clk) disable iff (!rst_n)
      oc_flag |=> (!gate_hi && !gate_lo));

   a_r9_uv_kill: assert property (@(posedge clk) disable iff (!rst_n)
      uv_flag |=> (!gate_hi && !gate_lo));

   if (SYNC_STAGES == 2) begin : g_lat2
      a_r2_sd_off: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(sd_line_n, 3) |-> (!gate_hi && !gate_lo));

      a_r3_interlock: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(cmd_hi, 3) && $past(cmd_lo, 3)) |-> (!gate_hi && !gate_lo));

      a_r8_pull_set: assert property (@(posedge clk) disable iff (!rst_n)
         $past(oc_flag, 3) |-> sd_pull);

      a_r8_pull_release: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(sd_pull) |-> !$past(sd_line_n, 3));
   end

endmodule

bind hb_gate_interlock hbgi_chk #(.DEAD_CYC(DEAD_CYC), .SYNC_STAGES(SYNC_STAGES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_hi    (cmd_hi),
   .cmd_lo    (cmd_lo),
   .sd_line_n (sd_line_n),
   .oc_flag   (oc_flag),
   .uv_flag   (uv_flag),
   .gate_hi   (gate_hi),
   .gate_lo   (gate_lo),
   .sd_pull   (sd_pull)
);

// File: tb/sim_hb_gate_interlock.sv
`timescale 1ns/1ps
module sim_hb_gate_interlock;

   localparam int DEAD = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_hi = 1'b0, cmd_lo = 1'b0, sd_line_n = 1'b1, oc_flag = 1'b0, uv_flag = 1'b0;
   logic gate_hi, gate_lo, sd_pull;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   always #5 clk = ~clk;

   hb_gate_interlock #(.DEAD_CYC(DEAD), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
      .sd_line_n(sd_line_n), .oc_flag(oc_flag), .uv_flag(uv_flag),
      .gate_hi(gate_hi), .gate_lo(gate_lo), .sd_pull(sd_pull)
   );

   // ---------------- reference model ----------------
   bit q_hi[$], q_lo[$], q_sd[$], q_oc[$];   // two-deep delay lines
   bit m_gh, m_gl, m_pull, m_arm;
   int m_run;

   task automatic model_reset();
      q_hi = '{0, 0}; q_lo = '{0, 0}; q_sd = '{0, 0}; q_oc = '{0, 0};
      m_gh = 0; m_gl = 0; m_pull = 0; m_arm = 0; m_run = 0;
   endtask

   initial model_reset();

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else begin
         bit hi2, lo2, sd2, oc2, off;
         bit n_gh, n_gl;
         hi2 = q_hi[0]; lo2 = q_lo[0]; sd2 = q_sd[0]; oc2 = q_oc[0];
         off = !sd2 || uv_flag || oc_flag || oc2 || m_pull;
         if (!m_gh && !m_gl) m_run++; else m_run = 0;
         n_gh = 0; n_gl = 0;
         if (!off && m_arm) begin
            if (hi2 && !lo2) n_gh = m_gh || (!m_gl && m_run >= DEAD);
            if (lo2 && !hi2) n_gl = m_gl || (!m_gh && m_run >= DEAD);
         end
         if (off) m_arm = 0;
         else if (!hi2 && !lo2) m_arm = 1;
         if (oc2) m_pull = 1;
         else if (!sd2) m_pull = 0;
         m_gh = n_gh; m_gl = n_gl;
         void'(q_hi.pop_front()); q_hi.push_back(cmd_hi);
         void'(q_lo.pop_front()); q_lo.push_back(cmd_lo);
         void'(q_sd.pop_front()); q_sd.push_back(sd_line_n);
         void'(q_oc.pop_front()); q_oc.push_back(oc_flag);
      end
   end

   task automatic check(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Compare against the model and watch for overlap on every falling edge.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("model gate_hi (R4)", gate_hi, m_gh);
         check("model gate_lo (R4)", gate_lo, m_gl);
         check("model sd_pull (R8)", sd_pull, m_pull);
         check("overlap R5", gate_hi && gate_lo, 0);
      end
   end

   task automatic finish_run();
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      #1_000_000;
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      int cnt;
      cyc(4);
      check("R1 reset gate_hi", gate_hi, 0);
      check("R1 reset gate_lo", gate_lo, 0);
      check("R1 reset sd_pull", sd_pull, 0);
      rst_n = 1'b1;
      cyc(1);
      check("R1 after release gate_hi", gate_hi, 0);
      check("R1 after release sd_pull", sd_pull, 0);
      cyc(10);

      // R11 / R4: high side on with 3-edge latency
      cmd_hi = 1'b1;
      cnt = 0;
      do begin cyc(1); cnt++; end while (!gate_hi && cnt < 20);
      check("R11 cmd_hi to gate_hi latency", cnt, 3);
      check("R4 high only gate_lo", gate_lo, 0);

      // R6: hand-over to low side, measure both-off gap
      cmd_hi = 1'b0; cmd_lo = 1'b1;
      cnt = 0;
      while (gate_hi && cnt < 20) begin cyc(1); cnt++; end
      cnt = 0;
      while (!gate_lo && cnt < 40) begin cyc(1); cnt++; end
      check("R6 dead-time gap hi->lo", cnt, DEAD);
      check("R4 low only gate_hi", gate_hi, 0);

      // R6 reverse direction
      cmd_lo = 1'b0; cmd_hi = 1'b1;
      cnt = 0;
      while (gate_lo && cnt < 20) begin cyc(1); cnt++; end
      cnt = 0;
      while (!gate_hi && cnt < 40) begin cyc(1); cnt++; end
      check("R6 dead-time gap lo->hi", cnt, DEAD);

      // R3: both commands high
      cmd_lo = 1'b1;
      cyc(2);
      check("R3 one edge before due gate_hi", gate_hi, 1);
      cyc(1);
      check("R3 interlock gate_hi", gate_hi, 0);
      check("R3 interlock gate_lo", gate_lo, 0);
      cmd_hi = 1'b0; cmd_lo = 1'b0;
      cyc(4);
      check("R4 both low gate_hi", gate_hi, 0);
      check("R4 both low gate_lo", gate_lo, 0);
      cmd_lo = 1'b1;
      cyc(DEAD + 3);
      check("R4 low side restored", gate_lo, 1);

      // R2: shutdown line low
      sd_line_n = 1'b0;
      cyc(2);
      check("R2 before due gate_lo", gate_lo, 1);
      cyc(1);
      check("R2 shutdown gate_lo", gate_lo, 0);
      sd_line_n = 1'b1;
      cyc(10);
      check("R10 no restart with command held", gate_lo, 0);
      cmd_lo = 1'b0;
      cyc(4);
      cmd_lo = 1'b1;
      cyc(3);
      check("R10 restart after quiet pair", gate_lo, 1);

      // R7 / R8: overcurrent
      cmd_lo = 1'b0; cmd_hi = 1'b1;
      cyc(DEAD + 6);
      check("R4 high side before trip", gate_hi, 1);
      oc_flag = 1'b1;
      cyc(1);
      check("R7 oc kill next edge gate_hi", gate_hi, 0);
      cyc(1);
      check("R8 pull not yet", sd_pull, 0);
      cyc(1);
      check("R8 pull set after 3 edges", sd_pull, 1);
      oc_flag = 1'b0;
      cyc(10);
      check("R8 pull held while line high", sd_pull, 1);
      check("R7 gates stay off while latched", gate_hi, 0);
      sd_line_n = 1'b0;
      cyc(2);
      check("R8 pull held before line seen", sd_pull, 1);
      cyc(1);
      check("R8 pull released", sd_pull, 0);
      sd_line_n = 1'b1;
      cmd_hi = 1'b0;
      cyc(4);
      cmd_hi = 1'b1;
      cyc(4);
      check("R10 restart after overcurrent", gate_hi, 1);

      // R9: undervoltage
      uv_flag = 1'b1;
      cyc(1);
      check("R9 uv kill next edge", gate_hi, 0);
      uv_flag = 1'b0;
      cyc(8);
      check("R10 no restart after uv", gate_hi, 0);
      cmd_hi = 1'b0;
      cyc(4);
      cmd_hi = 1'b1;
      cyc(4);
      check("R10 restart after uv", gate_hi, 1);
      cmd_hi = 1'b0;
      cyc(5);
      finish_run();
   end

endmodule